// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Logic Unit with Signed Set-Less-Than

This block is the purely combinational arithmetic stage of a small 16-bit processor. The instruction decoder drives a 3-bit operation code, and the block combines two register operands into a 16-bit result and a zero flag in the same cycle. It has no clock and no stored state.

Addition serves both register-to-register arithmetic and base-plus-offset address generation for loads and stores. Subtraction serves both arithmetic and the branch comparison: the branch logic looks only at the zero flag to decide branch-on-equal and branch-on-not-equal. The remaining operations are complement, logical shifts by a register-supplied amount, bitwise AND and OR, and a signed set-less-than that writes 1 or 0 into the result.

Top module: `slt_alu`

## Requirements
- R1: With op = 3'd0 (add), result equals (a + b) modulo 2^16.
- R2: With op = 3'd1 (subtract), result equals (a - b) modulo 2^16.
- R3: With op = 3'd2 (invert), result is the bitwise complement of a, and the value of b has no effect on result or zero.
- R4: With op = 3'd3 (shift left), result is a shifted left by b places with zeros entering at bit 0, for b from 0 to 15.
- R5: With op = 3'd4 (shift right), result is a shifted right by b places with zeros entering at bit 15, for b from 0 to 15.
- R6: For both shift codes, a shift amount b of 16 or more gives a result of zero.
- R7: With op = 3'd5 result is a AND b; with op = 3'd6 result is a OR b.
- R8: With op = 3'd7 (set-less-than), result is 16'd1 when a is less than b as two's-complement signed numbers, and 16'd0 otherwise; bits 15:1 are always zero.
- R9: For every operation code, zero is 1 exactly when all 16 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 3 | Operation code from the decoder |
| a | input | 16 | First operand |
| b | input | 16 | Second operand, also the shift amount |
| result | output | 16 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
Each operation code gets directed corner vectors first: operands at zero, all ones, the most negative and most positive signed values, and equal operands. These separate a wrong carry or borrow, an unsigned versus signed compare in set-less-than, and a zero flag that is stuck or inverted. Shifts are tried at every amount from 0 to 20, which tells a correct barrel stage from a missing or misrouted one and shows the out-of-range rule at 16 and beyond. Invert is repeated with one first operand against many second operands to show b is ignored. A long pseudo-random run over all codes then catches any remaining mix-up in the result selection.

// File: rtl/slt_alu_pkg.sv
package slt_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_INV = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_SLT = 3'd7
  } alu_op_e;

  // The adder works in subtract mode for both difference and signed compare.
  function automatic logic op_needs_sub(alu_op_e op);
    return (op == OP_SUB) || (op == OP_SLT);
  endfunction

  function automatic logic op_is_shift(alu_op_e op);
    return (op == OP_SHL) || (op == OP_SHR);
  endfunction

  // One-bit full adder, sum half.
  function automatic logic fa_sum(logic x, logic y, logic cin);
    return x ^ y ^ cin;
  endfunction

  // One-bit full adder, carry half.
  function automatic logic fa_carry(logic x, logic y, logic cin);
    return (x & y) | (cin & (x ^ y));
  endfunction

  // Signed less-than from the sign of the difference corrected by overflow.
  function automatic logic signed_lt(logic diff_msb, logic ovf);
    return diff_msb ^ ovf;
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import slt_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             lt
);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_eff;
  logic             ovf;

  // Two's-complement subtract: invert b and inject a carry at bit 0.
  assign b_eff    = b ^ {WIDTH{sub}};
  assign carry[0] = sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum[i]       = fa_sum(a[i], b_eff[i], carry[i]);
    assign carry[i + 1] = fa_carry(a[i], b_eff[i], carry[i]);
  end

  assign ovf = carry[WIDTH] ^ carry[WIDTH-1];
  assign lt  = signed_lt(sum[WIDTH-1], ovf);

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] value,
  input  logic [WIDTH-1:0] amount,
  input  logic             left,
  output logic [WIDTH-1:0] shifted,
  output logic             out_of_range
);

  localparam int SHW = $clog2(WIDTH);

  logic [WIDTH-1:0] pre_rev;
  logic [WIDTH-1:0] post_rev;
  logic [WIDTH-1:0] stage [0:SHW];

  // A left shift is a right shift of the bit-reversed operand.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign pre_rev[i]  = left ? value[WIDTH-1-i] : value[i];
    assign post_rev[i] = left ? stage[SHW][WIDTH-1-i] : stage[SHW][i];
  end

  assign stage[0] = pre_rev;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    assign stage[k + 1] = amount[k] ? (stage[k] >> (2 ** k)) : stage[k];
  end

  if (WIDTH > SHW) begin : g_oob
    assign out_of_range = |amount[WIDTH-1:SHW];
  end else begin : g_no_oob
    assign out_of_range = 1'b0;
  end

  assign shifted = out_of_range ? '0 : post_rev;

endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] inv_res,
  output logic [WIDTH-1:0] and_res,
  output logic [WIDTH-1:0] or_res
);

  assign inv_res = ~a;
  assign and_res = a & b;
  assign or_res  = a | b;

endmodule

// File: rtl/slt_alu.sv
module slt_alu
  import slt_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  alu_op_e          op_e;
  logic [WIDTH-1:0] sum_w;
  logic             lt_w;
  logic [WIDTH-1:0] shift_w;
  logic             shift_oob;
  logic [WIDTH-1:0] inv_w;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic [WIDTH-1:0] result_w;

  assign op_e = alu_op_e'(op);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a   (a),
    .b   (b),
    .sub (op_needs_sub(op_e)),
    .sum (sum_w),
    .lt  (lt_w)
  );

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .value        (a),
    .amount       (b),
    .left         (op_e == OP_SHL),
    .shifted      (shift_w),
    .out_of_range (shift_oob)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a       (a),
    .b       (b),
    .inv_res (inv_w),
    .and_res (and_w),
    .or_res  (or_w)
  );

  always_comb begin
    unique case (op_e)
      OP_ADD, OP_SUB: result_w = sum_w;
      OP_INV:         result_w = inv_w;
      OP_SHL, OP_SHR: result_w = shift_w;
      OP_AND:         result_w = and_w;
      OP_OR:          result_w = or_w;
      OP_SLT:         result_w = {{(WIDTH-1){1'b0}}, lt_w};
      default:        result_w = '0;
    endcase
  end

  assign result = result_w;
  assign zero   = ~|result_w;

endmodule

// File: rtl/slt_alu_chk.sv
module slt_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [2:0]       op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             shift_oob
);

  logic [WIDTH-1:0] back_add;
  logic [WIDTH-1:0] back_sub;

  always_comb begin
    back_add = result - b;
    back_sub = result + b;
    if (op == 3'd0) AST_ADD_UNDO: assert (back_add == a);                                   // R1
    if (op == 3'd1) AST_SUB_UNDO: assert (back_sub == a);                                   // R2
    if (op == 3'd2) AST_INV_COMPLEMENT: assert ((result ^ a) == '1);                        // R3
    if ((op == 3'd3 || op == 3'd4) && shift_oob) AST_SHIFT_RANGE: assert (result == '0);     // R6
    if (op == 3'd5) AST_AND_SUBSET: assert (((result & ~a) == '0) && ((result & ~b) == '0)); // R7
    if (op == 3'd6) AST_OR_COVER: assert (((result & a) == a) && ((result & b) == b));       // R7
    if (op == 3'd7) AST_SLT_BINARY: assert ((result >> 1) == '0);                            // R8
    if (zero) AST_ZERO_HIGH: assert ($countones(result) == 0);                               // R9
    if (!zero) AST_ZERO_LOW: assert ($countones(result) != 0);                               // R9
  end

endmodule

bind slt_alu slt_alu_chk #(.WIDTH(WIDTH)) u_slt_alu_chk (
  .op        (op),
  .a         (a),
  .b         (b),
  .result    (result),
  .zero      (zero),
  .shift_oob (shift_oob)
);

// File: tb/test_slt_alu.sv
`timescale 1ns/1ps
module test_slt_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op  = 3'd0;
  logic [15:0] a   = 16'd0;
  logic [15:0] b   = 16'd0;
  logic [15:0] result;
  logic        zero;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  always #10 clk = ~clk;

  slt_alu i_slt_alu (
    .op     (op),
    .a      (a),
    .b      (b),
    .result (result),
    .zero   (zero)
  );

  // Behavioural reference written with integers.
  function automatic int model(int o, int x, int y);
    int r;
    case (o)
      0: r = (x + y) % 65536;
      1: r = (x - y + 65536) % 65536;
      2: r = 65535 - x;
      3: r = (y >= 16) ? 0 : (x * (1 << y)) % 65536;
      4: r = (y >= 16) ? 0 : x / (1 << y);
      5: r = x & y;
      6: r = x | y;
      default: begin
        int sx, sy;
        sx = (x >= 32768) ? x - 65536 : x;
        sy = (y >= 32768) ? y - 65536 : y;
        r = (sx < sy) ? 1 : 0;
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(int o, int y);
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return (y >= 16) ? "R6" : "R4";
      4: return (y >= 16) ? "R6" : "R5";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic next_rand(output logic [15:0] v);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    v = lfsr[15:0] ^ lfsr[31:16];
  endtask

  // Drive after the rising edge, compare at the falling edge.
  task automatic apply(input int o, input int x, input int y);
    int exp_r;
    @(posedge clk);
    op = o[2:0];
    a  = x[15:0];
    b  = y[15:0];
    @(negedge clk);
    exp_r = model(o, x, y);
    n_cmp++;
    if (result !== exp_r[15:0]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h result actual=%h expected=%h",
               tag_of(o, y), o, x[15:0], y[15:0], result, exp_r[15:0]);
    end
    n_cmp++;
    if (zero !== (exp_r == 0)) begin
      n_bad++;
      $display("FAIL R9 op=%0d a=%h b=%h zero actual=%b expected=%b",
               o, x[15:0], y[15:0], zero, (exp_r == 0));
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired, actual=%0d cycles expected<=150000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] rx, ry;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Idle inputs: add of zeros gives zero with the flag set (R1, R9).
    @(negedge clk);
    n_cmp++;
    if (result !== 16'd0 || zero !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 idle actual=%h/%b expected=0000/1", result, zero);
    end

    // R1 add corners, including wrap and address-style offsets.
    apply(0, 0, 0); apply(0, 16'hFFFF, 1); apply(0, 16'h7FFF, 1); apply(0, 16'h1000, 16'h0004);
    // R2 subtract corners, equal operands drive the zero flag (R9).
    apply(1, 5, 5); apply(1, 0, 1); apply(1, 16'h8000, 1); apply(1, 16'h1234, 16'h0234);
    // R3 invert: fixed a, varied b must give identical outputs.
    apply(2, 16'hFFFF, 0); apply(2, 16'hA5C3, 0); apply(2, 16'hA5C3, 16'hFFFF);
    apply(2, 16'hA5C3, 16'h1234); apply(2, 0, 16'hFFFF);
    // R4, R5, R6 every amount from 0 to 20 and a huge amount.
    for (int s = 0; s <= 20; s++) begin
      apply(3, 16'h8001, s);
      apply(4, 16'h8001, s);
      apply(3, 16'hFFFF, s);
      apply(4, 16'hFFFF, s);
    end
    apply(3, 16'hFFFF, 16'h8000); apply(4, 16'hFFFF, 16'h0100);
    // R7 logic corners.
    apply(5, 16'hF0F0, 16'h0F0F); apply(5, 16'hFFFF, 16'h1234);
    apply(6, 16'hF0F0, 16'h0F0F); apply(6, 0, 0);
    // R8 signed compare corners.
    apply(7, 16'h8000, 16'h7FFF); apply(7, 16'h7FFF, 16'h8000); apply(7, 5, 5);
    apply(7, 16'hFFFF, 0); apply(7, 0, 16'hFFFF); apply(7, 3, 4); apply(7, 16'h8000, 16'h8001);

    // Pseudo-random sweep over all codes.
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 300; k++) begin
        next_rand(rx);
        next_rand(ry);
        if ((o == 3 || o == 4) && k < 200) ry = ry % 16'd20;
        if (o == 7 && k % 3 == 0) ry = rx;
        apply(o, rx, ry);
      end
    end
    finish_run();
  end

endmodule